// File: doc/BRIEF.md
# Printer Port Host Register Block

This block gives a host a byte-wide register window onto a standard printer parallel port and models a simple printer on the far side. The host reaches three registers through a 3-bit offset with separate read and write strobes: a data register, a status register and a control register. Reads return data combinationally in the same cycle. Read side effects, and all writes, take effect at the clock edge that ends the access.

Writing the control register runs the strobe handshake. When the strobe completes, the byte held in the write latch is sent out as a one-cycle valid pulse. The handshake state is held in the busy and acknowledge bits of the status register. These bits then step through a fixed sequence as the host polls status.

An interrupt flag is set by a control write that takes strobe low while select is active, init is released and interrupt enable is already stored. A status read clears the flag. The flag drives a registered level output.

The busy/acknowledge pair is an enumerated state machine. Each state value is the pair {busy-complement, ack}:

- HS_READY (11): the printer is idle.
- HS_TAKEN (01): a byte has been taken.
- HS_ACKING (00): acknowledge is low.
- HS_READY_NOACK (10): idle, with acknowledge low.

Its transitions are:

- T_INIT: any state to HS_READY, on a control write with init clear.
- T_STROBE: HS_READY to HS_TAKEN, and HS_READY_NOACK to HS_ACKING, on a strobe-high write.
- T_ACKDROP: HS_TAKEN to HS_ACKING, on a status read while the stored strobe is low.
- T_RELEASE: HS_ACKING to HS_READY, on a status read while the stored strobe is low.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, a data read gives 0xFF, a status read gives 0xD9 and a control read gives 0xCC. The irq and prn_valid outputs are 0.
- R2: Offset 0 is data, 1 is status and 2 is control. Offsets 3 to 7 read 0xFF. Writes to offsets 1 and 3 to 7 change nothing.
- R3: Every control write stores the written byte with bits 7 and 6 forced to 1.
- R4: A data write loads the write latch. A data read gives the write latch while control bit 5 (direction) is 0, and gives the read latch (0xFF) while it is 1.
- R5: A control write with bit 2 (init) clear sets status to 0xD8 from the next cycle on.
- R6: A control write with bit 2 set, bit 3 (select) set and bit 0 (strobe) set clears status bit 7 (busy-complement). If the stored strobe bit was 0 before this write, prn_valid is high for exactly the next cycle, and prn_byte carries the write latch.
- R7: A control write with bit 2 set, bit 3 set and bit 0 clear sets the interrupt flag when the stored control bit 4 (enable) is 1. irq is high from the next cycle on.
- R8: A status read clears the interrupt flag, and irq is low from the next cycle on.
- R9: A status read with status bit 7 at 0 and stored strobe at 0 does one of two things. If status bit 6 (ack) is set, the read clears it. If ack is clear, the read sets bits 7 and 6. In all other cases a status read leaves status unchanged. Every status read returns the value from before its own update.
- R10: When a read and a write hit the same offset in one cycle, the read returns the value from before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, same cycle |
| irq | output | 1 | Registered interrupt level |
| prn_valid | output | 1 | One-cycle pulse for an emitted byte |
| prn_byte | output | 8 | Emitted byte, valid with prn_valid |

## Verification
The bus has a single offset, so a status read and a control write can never share a cycle. The functions that can meet are a read and a write to the same register: a data or control readback taken in the same cycle that the register is rewritten. The bench raises both strobes together at the data and control offsets, in directed cases and at random. It expects the returned byte to equal the model's value from before the write, and expects the following readback to show the new value.

// File: rtl/prn_pkg.sv
package prn_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;
    localparam int STLO_W = BYTE_W - 2;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [BYTE_W-1:0] CTL_FORCE   = 8'hC0;
    localparam logic [BYTE_W-1:0] CTL_RESET   = 8'hCC;
    localparam logic [BYTE_W-1:0] LATCH_RESET = 8'hFF;
    localparam logic [BYTE_W-1:0] OPEN_READ   = 8'hFF;
    localparam logic [STLO_W-1:0] STLO_RESET  = 6'h19;
    localparam logic [STLO_W-1:0] STLO_INIT   = 6'h18;

    // value = {busy-complement, ack}
    typedef enum logic [1:0] {
        HS_READY       = 2'b11,
        HS_TAKEN       = 2'b01,
        HS_ACKING      = 2'b00,
        HS_READY_NOACK = 2'b10
    } hs_state_t;

    typedef enum logic [1:0] {
        CA_INIT,
        CA_STROBE_HI,
        CA_STROBE_LO,
        CA_PASSIVE
    } ctl_act_t;

    function automatic ctl_act_t ctl_decode(input logic init_b, input logic sel_b,
                                            input logic stb_b);
        if (!init_b)     return CA_INIT;
        else if (!sel_b) return CA_PASSIVE;
        else if (stb_b)  return CA_STROBE_HI;
        else             return CA_STROBE_LO;
    endfunction
endpackage

// File: rtl/prn_hs_fsm.sv
module prn_hs_fsm
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  ctl_act_t          ctl_act,
    input  logic              st_rd,
    input  logic              stb_q,
    output logic [BYTE_W-1:0] status
);
    hs_state_t         st_q, st_d;
    logic [STLO_W-1:0] lo_q;

    always_comb begin
        st_d = st_q;
        if (st_rd && !stb_q) begin
            unique case (st_q)
                HS_TAKEN:  st_d = HS_ACKING;   // T_ACKDROP
                HS_ACKING: st_d = HS_READY;    // T_RELEASE
                default:   st_d = st_q;
            endcase
        end
        if (ctl_wr) begin
            unique case (ctl_act)
                CA_INIT:      st_d = HS_READY;                        // T_INIT
                CA_STROBE_HI: st_d = hs_state_t'({1'b0, st_d[0]});    // T_STROBE
                default:      st_d = st_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_READY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           lo_q <= STLO_RESET;
        else if (ctl_wr && ctl_act == CA_INIT) lo_q <= STLO_INIT;
    end

    always_comb status = {st_q, lo_q};

    AST_INIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_act == CA_INIT |=> status == 8'hD8); // R5
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_act == CA_STROBE_HI |=> !status[7]); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && !stb_q && !ctl_wr && status[7:6] == 2'b00 |=> status[7:6] == 2'b11); // R9
endmodule

// File: rtl/prn_ctl_path.sv
module prn_ctl_path
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  ctl_act_t          ctl_act,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] wl_q,
    output logic              emit_valid,
    output logic [BYTE_W-1:0] emit_byte
);
    logic fire;
    always_comb fire = ctl_wr && (ctl_act == CA_STROBE_HI) && !ctl_q[CT_STB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            wl_q  <= LATCH_RESET;
        end else begin
            if (ctl_wr) ctl_q <= wdata | CTL_FORCE;
            if (dat_wr) wl_q  <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_valid <= 1'b0;
            emit_byte  <= LATCH_RESET;
        end else begin
            emit_valid <= fire;
            if (fire) emit_byte <= wl_q;
        end
    end

    AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |=> !emit_valid); // R6
    AST_CTL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_q[7:6] == 2'b11); // R3
endmodule

// File: rtl/prn_irq_pend.sv
module prn_irq_pend
    import prn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_wr,
    input  ctl_act_t ctl_act,
    input  logic     ien_q,
    input  logic     st_rd,
    output logic     irq
);
    logic set_p;
    always_comb set_p = ctl_wr && (ctl_act == CA_STROBE_LO) && ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     irq <= 1'b0;
        else if (set_p) irq <= 1'b1;
        else if (st_rd) irq <= 1'b0;
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_p |=> irq); // R7
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && !ctl_wr |=> !irq); // R8
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    output logic              prn_valid,
    output logic [BYTE_W-1:0] prn_byte
);
    logic              st_rd, ctl_wr, dat_wr;
    ctl_act_t          act;
    logic [BYTE_W-1:0] ctl_q, wl_q, status;

    always_comb begin
        st_rd  = bus_rd && (bus_addr == OFS_STAT);
        ctl_wr = bus_wr && (bus_addr == OFS_CTRL);
        dat_wr = bus_wr && (bus_addr == OFS_DATA);
        act    = ctl_decode(bus_wdata[CT_INIT], bus_wdata[CT_SEL], bus_wdata[CT_STB]);
    end

    prn_ctl_path u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dat_wr(dat_wr), .ctl_act(act),
        .wdata(bus_wdata), .ctl_q(ctl_q), .wl_q(wl_q),
        .emit_valid(prn_valid), .emit_byte(prn_byte)
    );

    prn_hs_fsm u_hs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_act(act),
        .st_rd(st_rd), .stb_q(ctl_q[CT_STB]), .status(status)
    );

    prn_irq_pend u_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_act(act),
        .ien_q(ctl_q[CT_IEN]), .st_rd(st_rd), .irq(irq)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = ctl_q[CT_DIR] ? LATCH_RESET : wl_q;
            OFS_STAT: bus_rdata = status;
            OFS_CTRL: bus_rdata = ctl_q;
            default:  bus_rdata = OPEN_READ;
        endcase
    end

    AST_CTL_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == OFS_CTRL |-> bus_rdata[7:6] == 2'b11); // R3
    AST_EMIT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid |-> ctl_q[CT_SEL] && ctl_q[CT_INIT] && ctl_q[CT_STB]); // R6
endmodule

// File: tb/prn_port_regs_tb_top.sv
`timescale 1ns/1ps
module prn_port_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, prn_byte;
    logic       irq, prn_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_wl, m_ctl, m_st, m_eb;
    logic       m_pend, m_emit;

    always #2 clk = ~clk;

    prn_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .prn_valid(prn_valid), .prn_byte(prn_byte)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] o);
        case (o)
            3'd0:    return m_ctl[5] ? 8'hFF : m_wl;
            3'd1:    return m_st;
            3'd2:    return m_ctl;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic m_rd_effect(input logic [2:0] o);
        if (o == 3'd1) begin
            m_pend = 1'b0;
            if (!m_st[7] && !m_ctl[0]) begin
                if (m_st[6]) m_st[6] = 1'b0;
                else         m_st[7:6] = 2'b11;
            end
        end
    endtask

    task automatic m_wr_effect(input logic [2:0] o, input logic [7:0] d);
        logic [7:0] v;
        if (o == 3'd0) m_wl = d;
        else if (o == 3'd2) begin
            v = d | 8'hC0;
            if (!v[2]) m_st = 8'hD8;
            else if (v[3]) begin
                if (v[0]) begin
                    m_st[7] = 1'b0;
                    if (!m_ctl[0]) begin m_emit = 1'b1; m_eb = m_wl; end
                end else if (m_ctl[4]) m_pend = 1'b1;
            end
            m_ctl = v;
        end
    endtask

    // one access, then one idle cycle in which the edge effects are judged
    task automatic access(input bit rd, input bit wr, input logic [2:0] o,
                          input logic [7:0] d, input string req);
        logic [7:0] e;
        @(negedge clk);
        chk(prn_valid == 1'b0, "R6 pulse width", {7'd0, prn_valid}, 8'h00);
        bus_addr = o; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        #1;
        if (rd) begin
            e = m_read(o);
            chk(bus_rdata == e, req, bus_rdata, e);
        end
        m_emit = 1'b0;
        if (rd) m_rd_effect(o);
        if (wr) m_wr_effect(o, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk(prn_valid == m_emit, "R6 emit valid", {7'd0, prn_valid}, {7'd0, m_emit});
        if (m_emit) chk(prn_byte == m_eb, "R6 emit byte", prn_byte, m_eb);
        chk(irq == m_pend, "R7/R8 irq level", {7'd0, irq}, {7'd0, m_pend});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=00 expected=01");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] o;
        logic [7:0] d;
        int r;
        void'($urandom(32'd715));
        m_wl = 8'hFF; m_ctl = 8'hCC; m_st = 8'hD9; m_pend = 1'b0; m_emit = 1'b0; m_eb = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R1 irq reset", {7'd0, irq}, 8'h00);
        chk(prn_valid == 1'b0, "R1 valid reset", {7'd0, prn_valid}, 8'h00);
        access(1, 0, 3'd0, 8'h00, "R1 data reset");
        access(1, 0, 3'd2, 8'h00, "R1 control reset");
        access(1, 0, 3'd1, 8'h00, "R1 status reset");
        // R2: unused offsets and status writes are inert
        access(1, 0, 3'd3, 8'h00, "R2 offset 3");
        access(1, 0, 3'd7, 8'h00, "R2 offset 7");
        access(0, 1, 3'd5, 8'h00, "R2 write ignored");
        access(0, 1, 3'd1, 8'h00, "R2 status write ignored");
        access(1, 0, 3'd1, 8'h00, "R2 status unchanged");
        access(1, 0, 3'd2, 8'h00, "R2 control unchanged");
        // R3 and R5
        access(0, 1, 3'd2, 8'h00, "R5 init clear");
        access(1, 0, 3'd2, 8'h00, "R3 forced top bits");
        access(1, 0, 3'd1, 8'h00, "R5 status D8");
        // R4
        access(0, 1, 3'd0, 8'h5A, "R4 data write");
        access(1, 0, 3'd0, 8'h00, "R4 write latch read");
        access(0, 1, 3'd2, 8'h2C, "R4 direction set");
        access(1, 0, 3'd0, 8'h00, "R4 read latch read");
        // R6 emission and R9 sequence
        access(0, 1, 3'd2, 8'h0C, "R6 strobe low");
        access(0, 1, 3'd0, 8'hA5, "R6 load byte");
        access(0, 1, 3'd2, 8'h0D, "R6 strobe rise");
        access(0, 1, 3'd2, 8'h0D, "R6 no second emit");
        access(1, 0, 3'd1, 8'h00, "R9 strobe high no step");
        access(0, 1, 3'd2, 8'h1C, "R7 enable not yet stored");
        access(0, 1, 3'd2, 8'h1C, "R7 pending set");
        access(1, 0, 3'd1, 8'h00, "R8 R9 read clears pend drops ack");
        access(1, 0, 3'd1, 8'h00, "R9 release");
        access(1, 0, 3'd1, 8'h00, "R9 ready stays");
        // R10 same-offset read and write
        access(1, 1, 3'd0, 8'h3C, "R10 data old value");
        access(1, 0, 3'd0, 8'h00, "R10 data new value");
        access(1, 1, 3'd2, 8'h1D, "R10 control old value");
        access(1, 0, 3'd2, 8'h00, "R10 control new value");
        // random phase
        for (int i = 0; i < 800; i++) begin
            r = $urandom_range(0, 9);
            if (r < 8) o = 3'(r % 3);
            else       o = 3'(3 + $urandom_range(0, 4));
            d = 8'($urandom());
            if ($urandom_range(0, 3) != 0) d[3:2] = 2'b11;
            r = $urandom_range(0, 5);
            access(r != 1, r < 2 || r == 5, o, d, "R2 R4 R9 R10 random read");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule